// File: doc/BRIEF.md
# ECC Error Logger with Write-One-Clear Status

This block sits beside a DRAM controller's ECC datapath and records memory errors for software. The datapath pulses a correctable-error or uncorrectable-error event together with the failing physical address, the channel number and the 8-bit ECC syndrome. The logger keeps the location and syndrome of one error in read-only registers. It also keeps sticky status flags for both ECC error classes and for three further sources: refresh timeout, a locked access to non-DRAM space, and a thermal sensor event.

Software reads and writes the unit through a small register port. Status flags are cleared by writing ones to them. A command register enables each flag, one at a time, as a source of the system-error output. Since there is only one log slot, the logging policy favours the more severe error. An uncorrectable error replaces the record of a correctable one. A correctable error never replaces a record that already exists.

Top module: `ecc_err_log`

## Requirements
- R1: Register select on `regAddr`: 0 = status, 1 = command, 2 = error address, 3 = extended address, 4 = syndrome; any other value reads zero. Status flag positions are: correctable bit 0, uncorrectable bit 1, refresh timeout bit 8, non-DRAM lock bit 9, thermal bit 11. Every other status bit reads zero.
- R2: A status flag stays set until software writes 1 to its bit position in the status register. Writing 0 to a flag leaves it unchanged.
- R3: When an event and a write-1 clear of the same flag fall in the same cycle, the flag ends up set. An event is sampled on the rising clock edge and shows in status at that edge.
- R4: When the log is empty, an error is captured as follows. The address register reads failing address bits 31:7 in bits 31:7, zeros in bits 6:1 and the channel in bit 0. The extended address register reads address bit 32 in bit 0 and zeros elsewhere. The syndrome register reads the error's syndrome.
- R5: An uncorrectable error that arrives while no uncorrectable error is logged overwrites the address, channel and syndrome registers, even when a correctable error is already held.
- R6: A correctable error that arrives while any error is logged only sets its flag. A further uncorrectable error that arrives while one is already logged also leaves the logged information unchanged.
- R7: The command register holds enable bits at the same five positions as the status flags. It is written directly, and its other bits read zero.
- R8: `sysErr` is set one clock after any status flag whose command bit is set becomes set. It drops one clock after no enabled flag remains.
- R9: Pulses on `refreshTo`, `lockNonDram` and `thermEvt` set status bits 8, 9 and 11 respectively.
- R10: After reset, every register reads zero and `sysErr` is low.
- R11: When a correctable and an uncorrectable error arrive in the same cycle on an empty log, both flags set and that cycle's address, channel and syndrome are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceEvt | input | 1 | Correctable ECC error event, one cycle |
| ueEvt | input | 1 | Uncorrectable ECC error event, one cycle |
| errAddr | input | 33 | Failing physical address |
| errChan | input | 1 | Channel of the failing access |
| errSyn | input | 8 | ECC syndrome of the failing access |
| refreshTo | input | 1 | Refresh timeout event |
| lockNonDram | input | 1 | Locked access to non-DRAM memory event |
| thermEvt | input | 1 | Thermal sensor event |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| sysErr | output | 1 | Registered system-error request |

## Verification
Some behaviours are checked by assertions on every cycle. Reserved status bits always read zero. A flag never drops without a matching write-one. An event always leaves its flag set on the next cycle, whatever clear is under way. `sysErr` always equals the previous cycle's enabled-flag OR. An uncorrectable capture always loads the syndrome, and a correctable event never moves a held record. Other behaviours only the bench scenarios can show: the full bit layout of the captured address and extended address, the command register's masking, the three auxiliary event sources, and the ordering sequences in which an uncorrectable error overwrites a correctable one.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int STS_W     = 16;
  localparam int BIT_CE    = 0;
  localparam int BIT_UE    = 1;
  localparam int BIT_RTO   = 8;
  localparam int BIT_LOCK  = 9;
  localparam int BIT_THERM = 11;

  localparam logic [STS_W-1:0] FLAG_MASK =
      (STS_W'(1) << BIT_CE)  | (STS_W'(1) << BIT_UE) |
      (STS_W'(1) << BIT_RTO) | (STS_W'(1) << BIT_LOCK) |
      (STS_W'(1) << BIT_THERM);

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_CMD    = 3'd1,
    SEL_ADDR   = 3'd2,
    SEL_EXT    = 3'd3,
    SEL_SYN    = 3'd4
  } regSel_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic             capture;
    logic [STS_W-1:0] setMask;
    logic [STS_W-1:0] clrMask;
    logic             cmdWr;
    logic [STS_W-1:0] cmdData;
  } logStrobe_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
#(
  parameter int RA_W = 3
) (
  input  logic             ceEvt,
  input  logic             ueEvt,
  input  logic             refreshTo,
  input  logic             lockNonDram,
  input  logic             thermEvt,
  input  logic             regWrEn,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [STS_W-1:0] wrLo,
  input  logic             ceLogged,
  input  logic             ueLogged,
  output logStrobe_t       strobe
);
  logic wrStatus;
  logic wrCmd;
  logic ueTakes;
  logic ceTakes;

  assign wrStatus = regWrEn && (regAddr == RA_W'(SEL_STATUS));
  assign wrCmd    = regWrEn && (regAddr == RA_W'(SEL_CMD));

  // severity policy: an uncorrectable error replaces anything but an earlier
  // uncorrectable one; a correctable one only fills an empty log
  assign ueTakes = ueEvt && !ueLogged;
  assign ceTakes = ceEvt && !ceLogged && !ueLogged;

  always_comb begin
    strobe = '0;
    strobe.capture = ueTakes || ceTakes;
    strobe.setMask[BIT_CE]    = ceEvt;
    strobe.setMask[BIT_UE]    = ueEvt;
    strobe.setMask[BIT_RTO]   = refreshTo;
    strobe.setMask[BIT_LOCK]  = lockNonDram;
    strobe.setMask[BIT_THERM] = thermEvt;
    strobe.clrMask = wrStatus ? (wrLo & FLAG_MASK) : '0;
    strobe.cmdWr   = wrCmd;
    strobe.cmdData = wrLo & FLAG_MASK;
  end
endmodule

// File: rtl/ecc_log_dp.sv
module ecc_log_dp
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W    = 33,
  parameter int DATA_W    = 32,
  parameter int GRAIN_LSB = 7,
  parameter int SYN_W     = 8,
  parameter int RA_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobe_t        strobe,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              errChan,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic [RA_W-1:0]   regAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              sysErr,
  output logic [STS_W-1:0]  statusVec,
  output logic [STS_W-1:0]  cmdVec,
  output logic [SYN_W-1:0]  synVec,
  output logic              ceLogged,
  output logic              ueLogged
);
  localparam int PAD_W = GRAIN_LSB - 1;

  logic [STS_W-1:0]            statusQ;
  logic [STS_W-1:0]            statusNext;
  logic [STS_W-1:0]            cmdQ;
  logic [ADDR_W-1:GRAIN_LSB]   addrQ;
  logic                        chanQ;
  logic [SYN_W-1:0]            synQ;
  logic [DATA_W-1:0]           addrWord;
  logic [DATA_W-1:0]           extWord;
  logic                        unusedLowAddr;

  assign unusedLowAddr = ^errAddr[GRAIN_LSB-1:0];

  // per-flag next state: a new event beats a clear in the same cycle
  always_comb begin
    statusNext = '0;
    for (int b = 0; b < STS_W; b++) begin
      if (FLAG_MASK[b]) begin
        statusNext[b] = strobe.setMask[b] | (statusQ[b] & ~strobe.clrMask[b]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      cmdQ    <= '0;
      sysErr  <= 1'b0;
    end else begin
      statusQ <= statusNext;
      if (strobe.cmdWr) cmdQ <= strobe.cmdData;
      sysErr  <= |(statusQ & cmdQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      chanQ <= 1'b0;
      synQ  <= '0;
    end else if (strobe.capture) begin
      addrQ <= errAddr[ADDR_W-1:GRAIN_LSB];
      chanQ <= errChan;
      synQ  <= errSyn;
    end
  end

  assign addrWord = {addrQ[DATA_W-1:GRAIN_LSB], {PAD_W{1'b0}}, chanQ};
  assign extWord  = DATA_W'(addrQ[ADDR_W-1:DATA_W]);

  always_comb begin
    case (regAddr)
      RA_W'(SEL_STATUS): regRdData = DATA_W'(statusQ);
      RA_W'(SEL_CMD):    regRdData = DATA_W'(cmdQ);
      RA_W'(SEL_ADDR):   regRdData = addrWord;
      RA_W'(SEL_EXT):    regRdData = extWord;
      RA_W'(SEL_SYN):    regRdData = DATA_W'(synQ);
      default:           regRdData = '0;
    endcase
  end

  assign statusVec = statusQ;
  assign cmdVec    = cmdQ;
  assign synVec    = synQ;
  assign ceLogged  = statusQ[BIT_CE];
  assign ueLogged  = statusQ[BIT_UE];
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W    = 33,
  parameter int DATA_W    = 32,
  parameter int GRAIN_LSB = 7,
  parameter int SYN_W     = 8,
  parameter int RA_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceEvt,
  input  logic              ueEvt,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              errChan,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic              refreshTo,
  input  logic              lockNonDram,
  input  logic              thermEvt,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sysErr
);
  logStrobe_t       strobe;
  logic [STS_W-1:0] statusVec;
  logic [STS_W-1:0] cmdVec;
  logic [SYN_W-1:0] synVec;
  logic             ceLogged;
  logic             ueLogged;
  logic             unusedWrHi;

  assign unusedWrHi = ^regWrData[DATA_W-1:STS_W];

  ecc_log_ctrl #(.RA_W(RA_W)) ctrl_i (
    .ceEvt      (ceEvt),
    .ueEvt      (ueEvt),
    .refreshTo  (refreshTo),
    .lockNonDram(lockNonDram),
    .thermEvt   (thermEvt),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .wrLo       (regWrData[STS_W-1:0]),
    .ceLogged   (ceLogged),
    .ueLogged   (ueLogged),
    .strobe     (strobe)
  );

  ecc_log_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAIN_LSB(GRAIN_LSB),
    .SYN_W(SYN_W), .RA_W(RA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .errAddr  (errAddr),
    .errChan  (errChan),
    .errSyn   (errSyn),
    .regAddr  (regAddr),
    .regRdData(regRdData),
    .sysErr   (sysErr),
    .statusVec(statusVec),
    .cmdVec   (cmdVec),
    .synVec   (synVec),
    .ceLogged (ceLogged),
    .ueLogged (ueLogged)
  );
endmodule

// File: rtl/ecc_log_chk.sv
module ecc_log_chk
  import ecc_log_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYN_W  = 8,
  parameter int RA_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceEvt,
  input logic              ueEvt,
  input logic [SYN_W-1:0]  errSyn,
  input logic              regWrEn,
  input logic [RA_W-1:0]   regAddr,
  input logic [STS_W-1:0]  wrLo,
  input logic [DATA_W-1:0] regRdData,
  input logic              sysErr,
  input logic [STS_W-1:0]  statusVec,
  input logic [STS_W-1:0]  cmdVec,
  input logic [SYN_W-1:0]  synVec
);
  localparam logic [DATA_W-1:0] RSVD = ~DATA_W'(FLAG_MASK);

  // R1: reserved status bits read zero
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == RA_W'(SEL_STATUS)) |-> ((regRdData & RSVD) == '0));

  // R2: a flag only falls after a write of 1 to its position
  a_r2_no_spurious_clear: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusVec) & ~statusVec) &
              ~(($past(regWrEn) && ($past(regAddr) == RA_W'(SEL_STATUS))) ?
                $past(wrLo) : '0)) == '0));

  // R3: an event leaves its flag set, whatever clear coincides
  a_r3_ce_sets: assert property (@(posedge clk) disable iff (!rstN)
    ceEvt |=> statusVec[BIT_CE]);
  a_r3_ue_sets: assert property (@(posedge clk) disable iff (!rstN)
    ueEvt |=> statusVec[BIT_UE]);

  // R5: an uncorrectable error on a log without one loads its syndrome
  a_r5_ue_capture: assert property (@(posedge clk) disable iff (!rstN)
    (ueEvt && !statusVec[BIT_UE]) |=> (synVec == $past(errSyn)));

  // R6: a correctable error never disturbs a held record
  a_r6_ce_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (ceEvt && !ueEvt && (statusVec[BIT_CE] || statusVec[BIT_UE])) |=> $stable(synVec));

  // R8: system error follows the enabled flags one cycle later
  a_r8_serr_lag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (sysErr == $past(|(statusVec & cmdVec))));
endmodule

bind ecc_err_log ecc_log_chk #(.DATA_W(DATA_W), .SYN_W(SYN_W), .RA_W(RA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .ceEvt    (ceEvt),
  .ueEvt    (ueEvt),
  .errSyn   (errSyn),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .wrLo     (regWrData[15:0]),
  .regRdData(regRdData),
  .sysErr   (sysErr),
  .statusVec(statusVec),
  .cmdVec   (cmdVec),
  .synVec   (synVec)
);

// File: tb/ecc_err_log_tb_top.sv
`timescale 1ns/1ps
module ecc_err_log_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceEvt = 1'b0;
  logic        ueEvt = 1'b0;
  logic [32:0] errAddr = '0;
  logic        errChan = 1'b0;
  logic [7:0]  errSyn = '0;
  logic        refreshTo = 1'b0;
  logic        lockNonDram = 1'b0;
  logic        thermEvt = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sysErr;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ecc_err_log dut_i (
    .clk(clk), .rstN(rstN), .ceEvt(ceEvt), .ueEvt(ueEvt), .errAddr(errAddr),
    .errChan(errChan), .errSyn(errSyn), .refreshTo(refreshTo),
    .lockNonDram(lockNonDram), .thermEvt(thermEvt), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sysErr(sysErr)
  );

  typedef struct packed {
    logic        ce;
    logic        ue;
    logic        clr;
    logic [32:0] addr;
    logic        chan;
    logic [7:0]  syn;
    logic [15:0] expSts;
    logic [31:0] expAddr;
    logic        expExt;
    logic [7:0]  expSyn;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b1, 33'h0_1234_5678, 1'b1, 8'h3C, 16'h0001, 32'h1234_5601, 1'b0, 8'h3C},
    '{1'b1, 1'b0, 1'b0, 33'h0_AAAA_AA80, 1'b0, 8'h11, 16'h0001, 32'h1234_5601, 1'b0, 8'h3C},
    '{1'b0, 1'b1, 1'b0, 33'h1_0000_0F00, 1'b0, 8'h7E, 16'h0003, 32'h0000_0F00, 1'b1, 8'h7E},
    '{1'b0, 1'b1, 1'b0, 33'h0_5555_5500, 1'b1, 8'h22, 16'h0003, 32'h0000_0F00, 1'b1, 8'h7E},
    '{1'b1, 1'b1, 1'b1, 33'h0_8000_00FF, 1'b1, 8'h99, 16'h0003, 32'h8000_0081, 1'b0, 8'h99},
    '{1'b0, 1'b1, 1'b1, 33'h0_0000_007F, 1'b0, 8'h05, 16'h0002, 32'h0000_0000, 1'b0, 8'h05}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulseErr(input logic ce, input logic ue, input logic [32:0] a,
                          input logic ch, input logic [7:0] s);
    @(negedge clk);
    ceEvt = ce; ueEvt = ue; errAddr = a; errChan = ch; errSyn = s;
    @(negedge clk);
    ceEvt = 1'b0; ueEvt = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    for (int r = 0; r < 5; r++) begin
      regRead(r[2:0], rd);
      check("R10", $sformatf("reg %0d after reset", r), rd, 32'h0);
    end
    check("R10", "sysErr after reset", {31'h0, sysErr}, 32'h0);

    // table: capture and overwrite ordering (R4 R5 R6 R11)
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].clr) regWrite(3'd0, 32'hFFFF_FFFF);
      pulseErr(TBL[i].ce, TBL[i].ue, TBL[i].addr, TBL[i].chan, TBL[i].syn);
      regRead(3'd0, rd);
      check("R11", $sformatf("vec %0d status", i), rd, {16'h0, TBL[i].expSts});
      regRead(3'd2, rd);
      check("R4", $sformatf("vec %0d address (R5/R6)", i), rd, TBL[i].expAddr);
      regRead(3'd3, rd);
      check("R4", $sformatf("vec %0d extended", i), rd, {31'h0, TBL[i].expExt});
      regRead(3'd4, rd);
      check("R5", $sformatf("vec %0d syndrome (R6)", i), rd, {24'h0, TBL[i].expSyn});
    end

    // R2: writing 0 keeps a flag, writing 1 clears only that flag
    regWrite(3'd0, 32'h0000_0000);
    regRead(3'd0, rd);
    check("R2", "write zero keeps flag", rd, 32'h0000_0002);
    pulseErr(1'b1, 1'b0, 33'h0, 1'b0, 8'h00);
    regWrite(3'd0, 32'h0000_0001);
    regRead(3'd0, rd);
    check("R2", "write one clears only its bit", rd, 32'h0000_0002);
    regWrite(3'd0, 32'hFFFF_FFFF);
    regRead(3'd0, rd);
    check("R2", "all flags cleared", rd, 32'h0);

    // R3: event and clear of the same flag in one cycle
    pulseErr(1'b1, 1'b0, 33'h0_0000_1000, 1'b0, 8'h44);
    @(negedge clk);
    ceEvt = 1'b1; regAddr = 3'd0; regWrData = 32'h1; regWrEn = 1'b1;
    @(negedge clk);
    ceEvt = 1'b0; regWrEn = 1'b0;
    regRead(3'd0, rd);
    check("R3", "set beats clear", rd, 32'h0000_0001);
    regWrite(3'd0, 32'hFFFF_FFFF);

    // R9: auxiliary sources
    @(negedge clk);
    refreshTo = 1'b1; lockNonDram = 1'b1; thermEvt = 1'b1;
    @(negedge clk);
    refreshTo = 1'b0; lockNonDram = 1'b0; thermEvt = 1'b0;
    regRead(3'd0, rd);
    check("R9", "aux flags", rd, 32'h0000_0B00);
    regWrite(3'd0, 32'hFFFF_FFFF);

    // R7: command register masking
    regWrite(3'd1, 32'hFFFF_FFFF);
    regRead(3'd1, rd);
    check("R7", "command reserved bits", rd, 32'h0000_0B03);

    // R1: unused selects read zero
    regRead(3'd5, rd);
    check("R1", "select 5 reads zero", rd, 32'h0);
    regRead(3'd7, rd);
    check("R1", "select 7 reads zero", rd, 32'h0);

    // R8: enable only the uncorrectable source
    regWrite(3'd1, 32'h0000_0002);
    pulseErr(1'b1, 1'b0, 33'h0, 1'b0, 8'h00);
    @(negedge clk);
    check("R8", "disabled source keeps sysErr low", {31'h0, sysErr}, 32'h0);
    pulseErr(1'b0, 1'b1, 33'h0, 1'b0, 8'h00);
    check("R8", "sysErr one cycle late", {31'h0, sysErr}, 32'h0);
    @(negedge clk);
    check("R8", "sysErr raised", {31'h0, sysErr}, 32'h1);
    regWrite(3'd0, 32'h0000_0002);
    check("R8", "sysErr still high at clear edge", {31'h0, sysErr}, 32'h1);
    @(negedge clk);
    check("R8", "sysErr dropped", {31'h0, sysErr}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule